// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of general-purpose pins on a 32-bit register bus. Each pin can be set up as an output that drives a programmed value, or as an input whose value software reads. Incoming pin values pass through a two-flop synchroniser before anything else uses them.

Each pin can raise an interrupt in two independent ways. The level source is live: it is active while the synchronised pin matches a programmed active level, and it has its own enable mask. The edge source detects a programmed transition, either rising or falling, and stores it in a sticky event register. Software clears that register by writing ones. The event is recorded even when the pin's edge mask is clear. The mask only decides whether the stored event counts as pending.

All per-pin pending bits are ORed into bit 0 of a top-level status register. A one-bit top-level enable then gates that bit onto the single interrupt output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and `irq_out` is low.
- R2: Bit i of the direction register (offset 0x48) drives `pin_oe[i]`, and bit i of the output register (offset 0x44) drives `pin_out[i]`. Both registers read back the value last written.
- R3: The input register (offset 0x40) returns `pin_in` after two synchronising flops. A value applied before a clock edge is readable from the second edge after it.
- R4: Pin i's level pending bit is (synchronised input XOR level polarity bit) AND level mask bit. The level polarity register is at 0x50 and the level mask at 0x54. A polarity of 1 means active-low.
- R5: The edge polarity register (offset 0x64) selects the edge per pin: 0 captures rising edges and 1 captures falling edges. A captured edge sets the pin's bit in the event register (offset 0x58), whatever the edge mask holds.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R7: If a new edge and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R8: Pin i's edge pending bit is event AND edge mask (offset 0x5C). Bit 0 of the top-level status register (offset 0x00) is the OR of all level and edge pending bits.
- R9: `irq_out` is status bit 0 AND bit 0 of the top-level mask register (offset 0x04).
- R10: Reads from unmapped offsets return zero and writes to them change nothing. Writes to the input register and to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | PINS | Asynchronous pin inputs |
| pin_out | output | PINS | Output data per pin |
| pin_oe | output | PINS | Output enable per pin |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The level path is tested with all 256 input patterns of an 8-pin bank. The sweep is repeated for four polarity and mask pairs, so that an inverted polarity, a missing mask or an AND/OR mix-up each gives a different wrong status. The edge path is driven with an all-rise and then an all-fall pattern under a mixed polarity register, which separates rising capture from falling capture pin by pin. A clearing write is then timed to land in the same cycle as a new edge, so the bench can tell whether the design gives priority to the capture or to the clear. Unmapped and read-only offsets are written with all-ones, and the outputs are read back to show that nothing changed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_W = 32;

  // byte offsets decoded by the bank
  localparam logic [7:0] OFF_TOP_STAT = 8'h00;
  localparam logic [7:0] OFF_TOP_MASK = 8'h04;
  localparam logic [7:0] OFF_DIN      = 8'h40;
  localparam logic [7:0] OFF_DOUT     = 8'h44;
  localparam logic [7:0] OFF_DIR      = 8'h48;
  localparam logic [7:0] OFF_LVL_POL  = 8'h50;
  localparam logic [7:0] OFF_LVL_MASK = 8'h54;
  localparam logic [7:0] OFF_EVT      = 8'h58;
  localparam logic [7:0] OFF_EVT_MASK = 8'h5C;
  localparam logic [7:0] OFF_EVT_POL  = 8'h64;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TOP_STAT,
    SEL_TOP_MASK,
    SEL_DIN,
    SEL_DOUT,
    SEL_DIR,
    SEL_LVL_POL,
    SEL_LVL_MASK,
    SEL_EVT,
    SEL_EVT_MASK,
    SEL_EVT_POL
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] off);
    reg_sel_e s;
    case (off)
      OFF_TOP_STAT: s = SEL_TOP_STAT;
      OFF_TOP_MASK: s = SEL_TOP_MASK;
      OFF_DIN:      s = SEL_DIN;
      OFF_DOUT:     s = SEL_DOUT;
      OFF_DIR:      s = SEL_DIR;
      OFF_LVL_POL:  s = SEL_LVL_POL;
      OFF_LVL_MASK: s = SEL_LVL_MASK;
      OFF_EVT:      s = SEL_EVT;
      OFF_EVT_MASK: s = SEL_EVT_MASK;
      OFF_EVT_POL:  s = SEL_EVT_POL;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

  // active when the pin differs from the programmed idle level
  function automatic logic [BUS_W-1:0] level_hit(input logic [BUS_W-1:0] din,
                                                 input logic [BUS_W-1:0] pol,
                                                 input logic [BUS_W-1:0] msk);
    return (din ^ pol) & msk;
  endfunction

  // a change whose new value differs from the polarity bit:
  // pol 0 -> new value 1 (rise), pol 1 -> new value 0 (fall)
  function automatic logic [BUS_W-1:0] edge_hit(input logic [BUS_W-1:0] cur,
                                                input logic [BUS_W-1:0] prev,
                                                input logic [BUS_W-1:0] pol);
    return (cur ^ prev) & (cur ^ pol);
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_level_detect.sv
module gpio_level_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] din_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] msk_i,
  output logic [N-1:0] pend_o
);

  logic [BUS_W-1:0] din_w;
  logic [BUS_W-1:0] pol_w;
  logic [BUS_W-1:0] msk_w;
  logic [BUS_W-1:0] hit_w;

  assign din_w  = BUS_W'(din_i);
  assign pol_w  = BUS_W'(pol_i);
  assign msk_w  = BUS_W'(msk_i);
  assign hit_w  = level_hit(din_w, pol_w, msk_w);
  assign pend_o = hit_w[N-1:0];

endmodule

// File: rtl/gpio_edge_event.sv
module gpio_edge_event
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] msk_i,
  output logic [N-1:0] ev_o,
  output logic [N-1:0] pend_o
);

  logic [N-1:0]     prev_q;
  logic [N-1:0]     ev_q;
  logic [N-1:0]     cap;
  logic [BUS_W-1:0] cap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  assign cap_w = edge_hit(BUS_W'(cur_i), BUS_W'(prev_q), BUS_W'(pol_i));
  assign cap   = cap_w[N-1:0];

  // one sticky flop per pin: capture has priority over the clear
  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ev_q[i] <= 1'b0;
      else if (cap[i])   ev_q[i] <= 1'b1;
      else if (clr_i[i]) ev_q[i] <= 1'b0;
    end
  end

  assign ev_o   = ev_q;
  assign pend_o = ev_q & msk_i;

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(ev_q & ~clr_i)) == $past(ev_q & ~clr_i))); // R6
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap) |=> ((ev_q & $past(cap)) == $past(cap))); // R7
  AST_NO_SPURIOUS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(cap)) == '0)); // R5

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq_out
);

  localparam int unsigned HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  reg_sel_e        sel;
  logic            hi_zero;
  logic [PINS-1:0] wdat;

  logic [PINS-1:0] dout_q, dir_q, lvl_pol_q, lvl_msk_q, evt_msk_q, evt_pol_q;
  logic            top_msk_q;

  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] lvl_pend;
  logic [PINS-1:0] evt_q;
  logic [PINS-1:0] evt_pend;
  logic [PINS-1:0] evt_clr;
  logic [PINS-1:0] pin_pend;
  logic            any_pend;
  logic            wr_dir;

  // decode: offsets above the byte range are unmapped
  generate
    if (ADDR_W > 8) begin : g_hi
      assign hi_zero = (bus_addr[ADDR_W-1:8] == HI_W'(0));
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel  = hi_zero ? decode_offset(bus_addr[7:0]) : SEL_NONE;
  assign wdat = bus_wdata[PINS-1:0];

  assign wr_dir  = bus_we && (sel == SEL_DIR);
  assign evt_clr = (bus_we && (sel == SEL_EVT)) ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dir_q     <= '0;
      lvl_pol_q <= '0;
      lvl_msk_q <= '0;
      evt_msk_q <= '0;
      evt_pol_q <= '0;
      top_msk_q <= 1'b0;
    end else if (bus_we) begin
      case (sel)
        SEL_DOUT:     dout_q    <= wdat;
        SEL_DIR:      dir_q     <= wdat;
        SEL_LVL_POL:  lvl_pol_q <= wdat;
        SEL_LVL_MASK: lvl_msk_q <= wdat;
        SEL_EVT_MASK: evt_msk_q <= wdat;
        SEL_EVT_POL:  evt_pol_q <= wdat;
        SEL_TOP_MASK: top_msk_q <= bus_wdata[0];
        default:      ;
      endcase
    end
  end

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pin_sync)
  );

  gpio_level_detect #(.N(PINS)) u_level (
    .din_i  (pin_sync),
    .pol_i  (lvl_pol_q),
    .msk_i  (lvl_msk_q),
    .pend_o (lvl_pend)
  );

  gpio_edge_event #(.N(PINS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (pin_sync),
    .pol_i  (evt_pol_q),
    .clr_i  (evt_clr),
    .msk_i  (evt_msk_q),
    .ev_o   (evt_q),
    .pend_o (evt_pend)
  );

  assign pin_pend = lvl_pend | evt_pend;
  assign any_pend = |pin_pend;
  assign irq_out  = any_pend & top_msk_q;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;

  always_comb begin
    case (sel)
      SEL_TOP_STAT: bus_rdata = {31'b0, any_pend};
      SEL_TOP_MASK: bus_rdata = {31'b0, top_msk_q};
      SEL_DIN:      bus_rdata = BUS_W'(pin_sync);
      SEL_DOUT:     bus_rdata = BUS_W'(dout_q);
      SEL_DIR:      bus_rdata = BUS_W'(dir_q);
      SEL_LVL_POL:  bus_rdata = BUS_W'(lvl_pol_q);
      SEL_LVL_MASK: bus_rdata = BUS_W'(lvl_msk_q);
      SEL_EVT:      bus_rdata = BUS_W'(evt_q);
      SEL_EVT_MASK: bus_rdata = BUS_W'(evt_msk_q);
      SEL_EVT_POL:  bus_rdata = BUS_W'(evt_pol_q);
      default:      bus_rdata = '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> top_msk_q); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((lvl_pend | evt_pend) != '0)); // R8
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == 32'd0)); // R10

endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;

  localparam int PINS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.PINS(PINS), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] pols[4];
    logic [7:0] msks[4];
    pols = '{8'h00, 8'hFF, 8'hA5, 8'h0F};
    msks = '{8'hFF, 8'hFF, 8'h3C, 8'h81};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 pin_oe", {24'b0, pin_oe}, 0);
    check("R1 pin_out", {24'b0, pin_out}, 0);
    check("R1 irq_out", {31'b0, irq_out}, 0);
    foreach (pols[k]) begin end
    begin
      logic [7:0] offs[10];
      offs = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h64};
      for (int k = 0; k < 10; k++) begin
        rd(offs[k], d);
        check("R1 register reset", d, 0);
      end
    end

    // R2: direction and output data
    wr(8'h48, 32'h0000_00A5);
    wr(8'h44, 32'h0000_003C);
    check("R2 pin_oe", {24'b0, pin_oe}, 32'hA5);
    check("R2 pin_out", {24'b0, pin_out}, 32'h3C);
    rd(8'h48, d); check("R2 dir readback", d, 32'hA5);
    rd(8'h44, d); check("R2 dout readback", d, 32'h3C);

    // R3: synchroniser latency - visible after second edge, not after first
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); bus_addr = 8'h40; #1 check("R3 after one edge", bus_rdata, 0);
    @(negedge clk); #1 check("R3 after two edges", bus_rdata, 32'h5A);
    set_pins(8'h00);

    // R4/R8/R9: level sweep, edge mask kept at zero
    for (int c = 0; c < 4; c++) begin
      wr(8'h50, {24'b0, pols[c]});
      wr(8'h54, {24'b0, msks[c]});
      wr(8'h04, {31'b0, c[1]});
      for (int v = 0; v < 256; v++) begin
        logic exp_s;
        set_pins(v[7:0]);
        exp_s = |((v[7:0] ^ pols[c]) & msks[c]);
        rd(8'h40, d); check("R3 input sweep", d, v);
        rd(8'h00, d); check("R4 level status", d, {31'b0, exp_s});
        check("R9 irq gating", {31'b0, irq_out}, {31'b0, exp_s & c[1]});
      end
    end
    wr(8'h54, 0);
    wr(8'h04, 0);

    // R5: edge selection, captured with mask clear
    wr(8'h64, 32'h0F);
    set_pins(8'h00);
    wr(8'h58, 32'hFF);
    rd(8'h58, d); check("R6 clear all", d, 0);
    set_pins(8'hFF);
    rd(8'h58, d); check("R5 rising on pol0 pins", d, 32'hF0);
    set_pins(8'h00);
    rd(8'h58, d); check("R5 falling on pol1 pins", d, 32'hFF);
    rd(8'h00, d); check("R8 masked events not pending", d, 0);

    // R6: write-one-to-clear
    wr(8'h58, 32'h55);
    rd(8'h58, d); check("R6 W1C", d, 32'hAA);
    wr(8'h58, 32'h00);
    rd(8'h58, d); check("R6 write zero keeps", d, 32'hAA);

    // R8/R9: edge pending into status and irq
    wr(8'h5C, 32'h02);
    rd(8'h00, d); check("R8 edge pending status", d, 1);
    check("R9 irq masked at top", {31'b0, irq_out}, 0);
    wr(8'h04, 32'h1);
    check("R9 irq enabled", {31'b0, irq_out}, 1);
    wr(8'h5C, 32'h01);
    rd(8'h00, d); check("R8 unset event bit", d, 0);
    check("R9 irq no source", {31'b0, irq_out}, 0);
    wr(8'h5C, 0);
    wr(8'h04, 0);

    // R7: edge and clear in the same cycle on pin 0 (rising)
    wr(8'h64, 32'h00);
    wr(8'h58, 32'hFF);
    @(negedge clk); pin_in = 8'h01;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h58; bus_wdata = 32'h01; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(8'h58, d); check("R7 edge wins over clear", d, 32'h01);
    wr(8'h58, 32'h01);
    rd(8'h58, d); check("R6 clear after collision", d, 0);

    // R10: unmapped and read-only offsets
    rd(8'h08, d); check("R10 unmapped 0x08", d, 0);
    rd(8'h4C, d); check("R10 unmapped 0x4C", d, 0);
    rd(8'h60, d); check("R10 unmapped 0x60", d, 0);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    check("R10 pin_oe unchanged", {24'b0, pin_oe}, 32'hA5);
    check("R10 pin_out unchanged", {24'b0, pin_out}, 32'h3C);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R10 input read-only", d, 32'h01);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R10 status read-only", d, 0);
    rd(8'h04, d); check("R10 top mask untouched", d, 0);
    check("R10 irq stays low", {31'b0, irq_out}, 0);

    done = 1;
    finish_run();
  end

endmodule